// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This unit feeds a pipeline with a stream of mixed 16-bit and 32-bit instructions. It reads an instruction memory whose data arrives one clock after the address is presented. Because an instruction's length is known only from its own bits, the unit does not compute the next address from the instruction just read. It requests aligned 32-bit words ahead of time into a small halfword buffer. It then peels complete instructions off the front of that buffer, joining halves across word boundaries where needed, and keeps the program counter of the instruction at the head.

A later stage resolves branches and sends a redirect with a target address. The redirect empties the buffer. Any word still on its way back from memory is marked stale with a one-bit epoch and discarded. Fetching restarts at the word that holds the target, and the lower halfword is skipped when the target sits in the upper half of its word.

Delivered instructions leave on a valid/ready interface. `ins_valid` never depends on `ins_ready`. A transfer happens on a rising edge where both are high. While `ins_valid` is high and `ins_ready` is low, the instruction, its width flag and its address are held unchanged. A redirect is the only exception: it withdraws the offered instruction on the next edge. If the transfer and the redirect fall on the same edge, the instruction counts as transferred.

Top module: `vlen_fetch`

## Requirements
- R1: While `rst_n` is low, `ins_valid` is low. After release, the first memory request carries the word address of `BOOT_ADDR` (low two bits cleared), and the first delivered instruction reports `ins_pc` = `BOOT_ADDR`.
- R2: An instruction is 32 bits wide when bits [1:0] of its first halfword are both 1; otherwise it is 16 bits wide. `ins_wide` reports this. A 16-bit instruction appears in `ins_word[15:0]`, with `ins_word[31:16]` zero. A 32-bit instruction has its first halfword in `ins_word[15:0]` and its second halfword in `ins_word[31:16]`.
- R3: After each transfer, `ins_pc` advances by 2 for a 16-bit instruction and by 4 for a 32-bit one.
- R4: A 32-bit instruction at an address with bit 1 set is assembled from bits [31:16] of one memory word (its low half) and bits [15:0] of the following word (its high half). Halfword 0 of a word is its bits [15:0].
- R5: Every memory request address is word aligned. The word for a request sampled on one rising edge is taken from `imem_rdata` during the following cycle.
- R6: After a redirect to a word-aligned target, with `ins_ready` held high, `ins_valid` first rises two cycles after the cycle in which the redirect was sampled. After that, one instruction transfers in every cycle with no gap.
- R7: While `ins_valid` is high and `ins_ready` is low, and no redirect is present, `ins_valid`, `ins_word`, `ins_wide` and `ins_pc` stay unchanged on the next cycle.
- R8: In the two cycles after a redirect is sampled, `ins_valid` is low. The first instruction delivered afterwards is the one at the target, with `ins_pc` equal to the target.
- R9: When the redirect target (or `BOOT_ADDR`) has bit 1 set, the lower halfword of the first returned word is dropped and delivery starts at the upper halfword.
- R10: A memory word requested before a redirect never enters the buffer, even when redirects arrive on consecutive cycles.
- R11: The buffer holds `CAP_HW` halfwords and never overflows. A word is requested only when the halfwords left after this cycle's transfer, plus any word in flight, plus two more, fit in `CAP_HW`. With the output stalled after a redirect to a word-aligned target, exactly `CAP_HW/2` words are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_req | input | 1 | Redirect request from branch resolution |
| flush_pc | input | ADDR_W | Redirect target address (bit 0 ignored) |
| imem_req | output | 1 | Memory read request this cycle |
| imem_addr | output | ADDR_W | Word-aligned read address |
| imem_rdata | input | 32 | Read data, valid the cycle after the request |
| ins_valid | output | 1 | A complete instruction is offered |
| ins_ready | input | 1 | Downstream accepts the offered instruction |
| ins_word | output | 32 | Instruction bits, first halfword in [15:0] |
| ins_wide | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| ins_pc | output | ADDR_W | Byte address of the offered instruction |

## Verification
The bench builds the unit with `ADDR_W` = 32, `CAP_HW` = 6 and `BOOT_ADDR` = 0x102. The boot address sits in the upper half of a word, and the halfword stored there encodes a 32-bit instruction. As a result, the very first delivery out of reset exercises the dropped lower half and the cross-word assembly. Six halfwords of storage make the stall-time request count (three words) and the gap-free streaming window observable at the ports. The memory content mixes both widths at both alignments.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  localparam int HALF_BITS = 16;
  localparam int WORD_BITS = 2 * HALF_BITS;

  typedef logic [HALF_BITS-1:0] half_t;

  // Width rule: both low bits set marks a 32-bit instruction.
  function automatic logic is_wide(input half_t h);
    return h[1:0] == 2'b11;
  endfunction
endpackage

// File: rtl/vlen_hbuf.sv
module vlen_hbuf
  import vlen_pkg::*;
#(
  parameter int CAP = 6,
  localparam int CW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    pop_n,
  input  logic [1:0]    push_n,
  input  half_t         push_a,
  input  half_t         push_b,
  output half_t         head0,
  output half_t         head1,
  output logic [CW-1:0] level
);
  half_t         slot_q [CAP];
  half_t         slot_d [CAP];
  logic [CW-1:0] cnt_q;

  // Shift out popped halfwords, then append arrivals behind the survivors.
  always_comb begin
    int kept;
    int src;
    kept = int'(cnt_q) - int'(pop_n);
    for (int i = 0; i < CAP; i++) begin
      src = i + int'(pop_n);
      slot_d[i] = slot_q[i];
      if (src < int'(cnt_q) && src < CAP) begin
        slot_d[i] = slot_q[src];
      end else if (push_n != 2'd0 && i == kept) begin
        slot_d[i] = push_a;
      end else if (push_n == 2'd2 && i == kept + 1) begin
        slot_d[i] = push_b;
      end
    end
  end

  for (genvar g = 0; g < CAP; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else        slot_q[g] <= slot_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (flush) cnt_q <= '0;
    else            cnt_q <= CW'(int'(cnt_q) - int'(pop_n) + int'(push_n));
  end

  assign head0 = slot_q[0];
  assign head1 = slot_q[1];
  assign level = cnt_q;

  // R11: arrivals never exceed the storage left after this cycle's pop.
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) - int'(pop_n) + int'(push_n) <= CAP);

  // R2: the output side never takes more halfwords than are held.
  p_pop_backed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(cnt_q));
endmodule

// File: rtl/vlen_reqgen.sv
module vlen_reqgen
  import vlen_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                CAP       = 6,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
  localparam int               CW        = $clog2(CAP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 redir,
  input  logic [ADDR_W-1:0]    redir_pc,
  input  logic [CW-1:0]        level_after_pop,
  output logic                 imem_req,
  output logic [ADDR_W-1:0]    imem_addr,
  input  logic [WORD_BITS-1:0] imem_rdata,
  output logic [1:0]           push_n,
  output half_t                push_a,
  output half_t                push_b
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] fetch_q;
  logic              epoch_q;
  logic              rsp_vld_q;
  logic              rsp_ep_q;
  logic              drop_q;
  logic              live;

  // A returning word counts only if it was requested in the current epoch.
  assign live = rsp_vld_q && (rsp_ep_q == epoch_q) && !redir;

  // Ask for a word only when it will surely fit beside what is held or in flight.
  assign imem_req  = int'(level_after_pop) + (live ? 2 : 0) + 2 <= CAP;
  assign imem_addr = fetch_q;

  always_comb begin
    push_n = 2'd0;
    push_a = imem_rdata[HALF_BITS-1:0];
    push_b = imem_rdata[WORD_BITS-1:HALF_BITS];
    if (live) begin
      if (drop_q) begin
        push_n = 2'd1;
        push_a = imem_rdata[WORD_BITS-1:HALF_BITS];
      end else begin
        push_n = 2'd2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q   <= BOOT_ADDR & WORD_MASK;
      epoch_q   <= 1'b0;
      rsp_vld_q <= 1'b0;
      rsp_ep_q  <= 1'b0;
      drop_q    <= BOOT_ADDR[1];
    end else begin
      rsp_vld_q <= imem_req;
      rsp_ep_q  <= epoch_q;
      if (redir) begin
        fetch_q <= redir_pc & WORD_MASK;
        epoch_q <= ~epoch_q;
        drop_q  <= redir_pc[1];
      end else begin
        if (imem_req) fetch_q <= fetch_q + WORD_STEP;
        if (live)     drop_q  <= 1'b0;
      end
    end
  end

  // R10: the word that returns right after a redirect is always stale.
  p_stale_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> push_n == 2'd0);

  // R5: requested addresses step by whole words between redirects.
  p_word_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req && !redir |=> imem_addr == $past(imem_addr) + WORD_STEP);
endmodule

// File: rtl/vlen_pcreg.sv
module vlen_pcreg #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir,
  input  logic [ADDR_W-1:0] redir_pc,
  input  logic              step,
  input  logic              wide,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] HALF_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= BOOT_ADDR & HALF_MASK;
    else if (redir) pc_q <= redir_pc & HALF_MASK;
    else if (step)  pc_q <= pc_q + (wide ? ADDR_W'(4) : ADDR_W'(2));
  end

  assign pc = pc_q;

  // R3: each transfer moves the address by the delivered width.
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step && !redir |=> pc == $past(pc) + ($past(wide) ? ADDR_W'(4) : ADDR_W'(2)));

  // R8: a redirect lands the address on the target halfword.
  p_pc_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> pc == ($past(redir_pc) & HALF_MASK));
endmodule

// File: rtl/vlen_fetch.sv
module vlen_fetch
  import vlen_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                CAP_HW    = 6,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_req,
  input  logic [ADDR_W-1:0]    flush_pc,
  output logic                 imem_req,
  output logic [ADDR_W-1:0]    imem_addr,
  input  logic [WORD_BITS-1:0] imem_rdata,
  output logic                 ins_valid,
  input  logic                 ins_ready,
  output logic [WORD_BITS-1:0] ins_word,
  output logic                 ins_wide,
  output logic [ADDR_W-1:0]    ins_pc
);
  localparam int CW = $clog2(CAP_HW + 1);

  half_t         head0;
  half_t         head1;
  logic [CW-1:0] level;
  logic [CW-1:0] level_after_pop;
  logic [1:0]    pop_n;
  logic [1:0]    push_n;
  half_t         push_a;
  half_t         push_b;
  logic          wide;
  logic          fire;

  assign wide      = is_wide(head0);
  assign ins_valid = (level != '0) && (!wide || level >= CW'(2));
  assign fire      = ins_valid && ins_ready;
  assign pop_n     = fire ? (wide ? 2'd2 : 2'd1) : 2'd0;
  assign level_after_pop = level - CW'(pop_n);

  assign ins_wide = wide;
  assign ins_word = wide ? {head1, head0} : {{HALF_BITS{1'b0}}, head0};

  vlen_hbuf #(.CAP(CAP_HW)) u_hbuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush_req),
    .pop_n  (pop_n),
    .push_n (push_n),
    .push_a (push_a),
    .push_b (push_b),
    .head0  (head0),
    .head1  (head1),
    .level  (level)
  );

  vlen_reqgen #(.ADDR_W(ADDR_W), .CAP(CAP_HW), .BOOT_ADDR(BOOT_ADDR)) u_reqgen (
    .clk             (clk),
    .rst_n           (rst_n),
    .redir           (flush_req),
    .redir_pc        (flush_pc),
    .level_after_pop (level_after_pop),
    .imem_req        (imem_req),
    .imem_addr       (imem_addr),
    .imem_rdata      (imem_rdata),
    .push_n          (push_n),
    .push_a          (push_a),
    .push_b          (push_b)
  );

  vlen_pcreg #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)) u_pcreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .redir    (flush_req),
    .redir_pc (flush_pc),
    .step     (fire),
    .wide     (wide),
    .pc       (ins_pc)
  );

  // R7: an offer that is not taken stays put.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready && !flush_req |=>
      ins_valid && $stable(ins_word) && $stable(ins_wide) && $stable(ins_pc));

  // R8: nothing is offered in the two cycles after a redirect.
  p_flush_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !ins_valid ##1 !ins_valid);
endmodule

// File: tb/vlen_fetch_tb_top.sv
module vlen_fetch_tb_top;
  localparam int          ADDR_W = 32;
  localparam int          CAP_HW = 6;
  localparam logic [31:0] BOOT   = 32'h0000_0102;

  // Each entry: target[47:16], instruction count[15:8], ready pattern[7:0].
  localparam logic [47:0] VEC [8] = '{
    {32'h0000_0000, 8'd14, 8'hFF},
    {32'h0000_0006, 8'd10, 8'hFF},
    {32'h0000_0010, 8'd12, 8'hA5},
    {32'h0000_0042, 8'd9,  8'h3C},
    {32'h0000_0100, 8'd16, 8'hFF},
    {32'h0000_03F8, 8'd8,  8'hFF},
    {32'h0000_020A, 8'd10, 8'h0F},
    {32'h0000_01E4, 8'd11, 8'h77}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush_req = 1'b0;
  logic [ADDR_W-1:0] flush_pc = '0;
  logic              imem_req;
  logic [ADDR_W-1:0] imem_addr;
  logic [31:0]       imem_rdata = '0;
  logic              ins_valid;
  logic              ins_ready = 1'b0;
  logic [31:0]       ins_word;
  logic              ins_wide;
  logic [ADDR_W-1:0] ins_pc;

  int checks = 0;
  int fails = 0;
  int misaligned = 0;
  int req_cnt = 0;
  int wd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vlen_fetch #(.ADDR_W(ADDR_W), .CAP_HW(CAP_HW), .BOOT_ADDR(BOOT)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_req  (flush_req),
    .flush_pc   (flush_pc),
    .imem_req   (imem_req),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .ins_valid  (ins_valid),
    .ins_ready  (ins_ready),
    .ins_word   (ins_word),
    .ins_wide   (ins_wide),
    .ins_pc     (ins_pc)
  );

  // Halfword contents, indexed by halfword; widths mix at both alignments.
  function automatic logic [15:0] hwv(input int k);
    logic [8:0] k9;
    logic [1:0] sel;
    k9  = 9'(k);
    sel = (k9 % 3 == 0) ? 2'b11 : {1'b0, k9[0]};
    return {k9[7:0] ^ 8'h5A, k9[5:0], sel};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int w;
    w = int'(a[9:2]);
    return {hwv(2 * w + 1), hwv(2 * w)};
  endfunction

  // Behavioural synchronous-read memory.
  always @(posedge clk) begin
    if (imem_req) imem_rdata <= mem_word(imem_addr);
  end

  always @(posedge clk) begin
    if (rst_n && imem_req) begin
      req_cnt <= req_cnt + 1;
      if (imem_addr[1:0] != 2'b00) misaligned <= misaligned + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 50000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      finish_run();
    end
  end

  // Collects n instructions starting at tgt; called at the negedge after the redirect is sampled.
  task automatic collect(input logic [31:0] tgt, input int n, input logic [7:0] pat, input bit gapchk);
    logic [31:0] pc;
    logic [31:0] ew;
    logic        ewide;
    string       tag;
    int got, cyc, first, last;
    pc = tgt; got = 0; cyc = 0; first = -1; last = -1;
    while (got < n) begin
      ins_ready = pat[cyc % 8];
      #1;
      if (cyc < 2) chk(!ins_valid, "R8 gap after redirect", 64'(ins_valid), 64'(0));
      if (ins_valid && ins_ready) begin
        ewide = hwv(int'(pc >> 1)) [1:0] == 2'b11;
        ew    = ewide ? {hwv(int'(pc >> 1) + 1), hwv(int'(pc >> 1))} : {16'h0, hwv(int'(pc >> 1))};
        if (ewide && pc[1]) tag = "R4 realigned wide";
        else if (ewide)     tag = "R2 wide";
        else                tag = "R2 narrow";
        chk({ins_wide, ins_word} == {ewide, ew}, tag, {31'h0, ins_wide, ins_word}, {31'h0, ewide, ew});
        chk(ins_pc == pc, (got == 0) ? "R8 first pc at target" : "R3 pc advance", 64'(ins_pc), 64'(pc));
        pc = pc + (ewide ? 32'd4 : 32'd2);
        if (first < 0) first = cyc;
        last = cyc;
        got++;
      end
      cyc++;
      @(negedge clk);
    end
    ins_ready = 1'b0;
    if (gapchk) begin
      chk(first == 2, "R6 first delivery cycle", 64'(first), 64'(2));
      chk(last - first == n - 1, "R6 no gap", 64'(last - first), 64'(n - 1));
    end
  endtask

  task automatic redirect(input logic [31:0] tgt);
    flush_req = 1'b1;
    flush_pc  = tgt;
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  initial begin
    logic [31:0] cap_w;
    logic [31:0] cap_pc;
    logic        cap_wide;
    bit          seen;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(!ins_valid, "R1 valid low in reset", 64'(ins_valid), 64'(0));
    end
    rst_n = 1'b1;
    #1;
    chk(imem_req && imem_addr == (BOOT & ~32'd3), "R1 first request at boot word",
        {31'h0, imem_req, imem_addr}, {31'h0, 1'b1, BOOT & ~32'd3});
    // R9 and R4: boot address in the upper halfword holds a wide instruction.
    collect(BOOT, 6, 8'hFF, 1'b0);

    // Table of redirect vectors, walked by one loop.
    for (int v = 0; v < 8; v++) begin
      logic [31:0] tgt;
      tgt = VEC[v][47:16];
      redirect(tgt);
      collect(tgt, int'(VEC[v][15:8]), VEC[v][7:0], VEC[v][7:0] == 8'hFF && !tgt[1]);
    end

    // R7 and R11: stall after a redirect to an aligned target.
    redirect(32'h0000_0020);
    req_cnt = 0;
    ins_ready = 1'b0;
    seen = 0;
    cap_w = '0; cap_pc = '0; cap_wide = 1'b0;
    for (int c = 0; c < 9; c++) begin
      #1;
      if (c == 2) begin
        cap_w = ins_word; cap_pc = ins_pc; cap_wide = ins_wide; seen = ins_valid;
        chk(seen, "R6 valid while stalled", 64'(ins_valid), 64'(1));
        chk(cap_pc == 32'h20, "R8 stalled pc", 64'(cap_pc), 64'(32'h20));
      end else if (c > 2) begin
        chk(ins_valid && {cap_wide, cap_w, cap_pc} == {ins_wide, ins_word, ins_pc}, "R7 hold under stall",
            {ins_valid, 30'h0, ins_wide, ins_word}, {1'b1, 30'h0, cap_wide, cap_w});
      end
      @(negedge clk);
    end
    chk(req_cnt == CAP_HW / 2, "R11 requests while stalled", 64'(req_cnt), 64'(CAP_HW / 2));

    // R8: redirect while an instruction is offered and stalled.
    redirect(32'h0000_0044);
    collect(32'h0000_0044, 7, 8'hFF, 1'b1);

    // R10: redirects on consecutive cycles; only the second target survives.
    flush_req = 1'b1;
    flush_pc  = 32'h0000_0080;
    @(negedge clk);
    flush_pc  = 32'h0000_00C6;
    @(negedge clk);
    flush_req = 1'b0;
    collect(32'h0000_00C6, 8, 8'hFF, 1'b0);

    // R10: a lone redirect in the middle of a busy stream.
    redirect(32'h0000_0300);
    ins_ready = 1'b1;
    @(negedge clk);
    redirect(32'h0000_0152);
    collect(32'h0000_0152, 6, 8'hDB, 1'b0);

    // R5: every request address word aligned.
    chk(misaligned == 0, "R5 aligned requests", 64'(misaligned), 64'(0));

    done = 1;
    finish_run();
  end
endmodule